// File: doc/BRIEF.md
# Paired-group logical PWM combiner

This block sits between a phase-shifted-carrier PWM generator and the sub-module gate drivers of one converter arm. It takes N gate signals and N capacitor voltage samples. Once per fundamental period, on a strobe, it ranks the sub-modules by voltage. It then pairs them into N/2 groups: group k holds the module ranked k-th from the top and the module ranked k-th from the bottom.

Each group compares its voltage spread (high minus low) against a programmable threshold. A group with a small spread passes two source gate signals straight through to its two modules. A group with a large spread drives its modules with the AND and the OR of the same two signals instead. The two sources sit half the module count apart in carrier phase. The OR, which has the longer on-time, charges the weaker module harder. The AND eases the stronger one. No arm current measurement is needed.

All routing decisions are frozen between strobes. The gate outputs come from a single register stage.

Top module: `pwm_pair_combiner`

## Requirements
- R1: While `rst` is high on a clock edge, `gate_out` and `combined` are cleared to zero on that edge. After reset and before the first strobe, the routing is as if all voltages were equal (module i holds rank i), with every group in direct mode.
- R2: At a strobe, modules are ranked by descending voltage. Rank 0 is the highest voltage. Between equal voltages, the lower module index takes the higher rank.
- R3: Group k (0 ≤ k < N/2) pairs the module of rank k, called its high module, with the module of rank N-1-k, called its low module.
- R4: Group k is in combined mode when the voltage of its high module minus the voltage of its low module is greater than or equal to `thresh`. Otherwise it is in direct mode. Both the voltages and `thresh` are taken in the strobe cycle.
- R5: In direct mode, the high module of group k receives `gate_in[k]` and the low module receives `gate_in[k+N/2]`.
- R6: In combined mode, the high module of group k receives `gate_in[k] & gate_in[k+N/2]` and the low module receives `gate_in[k] | gate_in[k+N/2]`.
- R7: `gate_out` is registered. A change on `gate_in` appears on `gate_out` after the next rising clock edge and not before it.
- R8: Ranking, grouping and mode change only on the edge where `period_stb` is high. Changes on `volt_flat` or `thresh` between strobes have no effect on `gate_out` or `combined`.
- R9: Bit k of `combined` is 1 exactly when group k is in combined mode (R4). It updates on the strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_stb | input | 1 | Fundamental-period update strobe, one cycle |
| thresh | input | VW | Convergence threshold, same unsigned units as voltages |
| volt_flat | input | N_MOD*VW | Voltage samples; module i at bits [i*VW +: VW] |
| gate_in | input | N_MOD | Phase-shifted source gate signals |
| gate_out | output | N_MOD | Registered per-module gate drives |
| combined | output | N_MOD/2 | Per-group combined-mode status |

## Verification
A wrong latched rank or mode surfaces on `gate_out` on the first clock edge after the strobe. It stays there, wrong, until the next strobe. The symptom is the wrong source signal on a module, or AND and OR landing on swapped modules. A mode error also shows at once on `combined`. Because the register holds the error for the whole period, the bench checks several cycles of varied gate patterns per strobe. It also probes ties, the exact threshold boundary, and voltage or threshold changes made between strobes.

// File: rtl/pwm_comb_pkg.sv
package pwm_comb_pkg;

    // Routing mode of one high/low group
    typedef enum logic {
        ROUTE_DIRECT   = 1'b0,
        ROUTE_COMBINED = 1'b1
    } route_mode_e;

    // Width needed to index n items (at least one bit)
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pwm_rank_sort.sv
module pwm_rank_sort
    import pwm_comb_pkg::*;
#(
    parameter int N_MOD = 8,
    parameter int VW    = 12,
    localparam int RW   = idx_bits(N_MOD)
) (
    input  logic [N_MOD*VW-1:0]         volt_flat,
    output logic [N_MOD-1:0][RW-1:0]    rank_of,
    output logic [N_MOD-1:0][VW-1:0]    volt_at_rank
);

    logic [VW-1:0] v [N_MOD];
    logic [RW:0]   cnt [N_MOD];

    for (genvar i = 0; i < N_MOD; i++) begin : g_unpack
        assign v[i] = volt_flat[i*VW +: VW];
    end

    // Rank = number of modules that beat this one (higher voltage, or equal with lower index)
    always_comb begin
        for (int i = 0; i < N_MOD; i++) begin
            cnt[i] = '0;
            for (int j = 0; j < N_MOD; j++) begin
                if (j != i && ((v[j] > v[i]) || ((v[j] == v[i]) && (j < i))))
                    cnt[i] = cnt[i] + (RW+1)'(1);
            end
            rank_of[i] = cnt[i][RW-1:0];
        end
    end

    // Voltage seen at each rank position
    always_comb begin
        for (int r = 0; r < N_MOD; r++) begin
            volt_at_rank[r] = '0;
            for (int i = 0; i < N_MOD; i++) begin
                if (rank_of[i] == RW'(r))
                    volt_at_rank[r] = volt_at_rank[r] | v[i];
            end
        end
    end

endmodule

// File: rtl/pwm_group_ctl.sv
module pwm_group_ctl
    import pwm_comb_pkg::*;
#(
    parameter int N_MOD = 8,
    parameter int VW    = 12,
    localparam int RW   = idx_bits(N_MOD),
    localparam int G    = N_MOD / 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      period_stb,
    input  logic [VW-1:0]             thresh,
    input  logic [N_MOD-1:0][RW-1:0]  rank_in,
    input  logic [N_MOD-1:0][VW-1:0]  volt_at_rank,
    output logic [N_MOD-1:0][RW-1:0]  rank_q,
    output logic [G-1:0]              combined
);

    route_mode_e mode_d [G];

    always_comb begin
        for (int k = 0; k < G; k++) begin
            mode_d[k] = ((volt_at_rank[k] - volt_at_rank[N_MOD-1-k]) >= thresh)
                        ? ROUTE_COMBINED : ROUTE_DIRECT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_MOD; i++) rank_q[i] <= RW'(i);
            combined <= '0;
        end else if (period_stb) begin
            rank_q <= rank_in;
            for (int k = 0; k < G; k++) combined[k] <= (mode_d[k] == ROUTE_COMBINED);
        end
    end

    // Latched ranks must remain a permutation of 0..N-1
    logic [N_MOD-1:0] seen;
    always_comb begin
        seen = '0;
        for (int i = 0; i < N_MOD; i++) seen[rank_q[i]] = 1'b1;
    end

    a_r2_rank_perm: assert property (@(posedge clk) disable iff (rst) (&seen));

    a_r8_hold_between_strobes: assert property (@(posedge clk) disable iff (rst)
        !period_stb |=> ($stable(combined) && $stable(rank_q)));

endmodule

// File: rtl/pwm_gate_mux.sv
module pwm_gate_mux
    import pwm_comb_pkg::*;
#(
    parameter int N_MOD = 8,
    localparam int RW   = idx_bits(N_MOD),
    localparam int G    = N_MOD / 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_MOD-1:0]          gate_in,
    input  logic [N_MOD-1:0][RW-1:0]  rank_q,
    input  logic [G-1:0]              combined,
    output logic [N_MOD-1:0]          gate_out
);

    logic [N_MOD-1:0] comb_ext;
    logic [N_MOD-1:0] gate_d;

    assign comb_ext = N_MOD'(combined);

    for (genvar i = 0; i < N_MOD; i++) begin : g_mod
        logic          is_high;
        logic [RW-1:0] grp;
        logic [RW-1:0] src_b;
        logic          a;
        logic          b;

        assign is_high = (rank_q[i] < RW'(G));
        assign grp     = is_high ? rank_q[i] : (RW'(N_MOD-1) - rank_q[i]);
        assign src_b   = grp + RW'(G);
        assign a       = gate_in[grp];
        assign b       = gate_in[src_b];

        always_comb begin
            if (comb_ext[grp]) gate_d[i] = is_high ? (a & b) : (a | b);
            else               gate_d[i] = is_high ? a : b;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) gate_out <= '0;
        else     gate_out <= gate_d;
    end

endmodule

// File: rtl/pwm_pair_combiner.sv
module pwm_pair_combiner
    import pwm_comb_pkg::*;
#(
    parameter int N_MOD = 8,
    parameter int VW    = 12,
    localparam int G    = N_MOD / 2,
    localparam int RW   = idx_bits(N_MOD)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  period_stb,
    input  logic [VW-1:0]         thresh,
    input  logic [N_MOD*VW-1:0]   volt_flat,
    input  logic [N_MOD-1:0]      gate_in,
    output logic [N_MOD-1:0]      gate_out,
    output logic [G-1:0]          combined
);

    logic [N_MOD-1:0][RW-1:0] rank_of;
    logic [N_MOD-1:0][VW-1:0] volt_at_rank;
    logic [N_MOD-1:0][RW-1:0] rank_q;

    pwm_rank_sort #(.N_MOD(N_MOD), .VW(VW)) u_sort (
        .volt_flat    (volt_flat),
        .rank_of      (rank_of),
        .volt_at_rank (volt_at_rank)
    );

    pwm_group_ctl #(.N_MOD(N_MOD), .VW(VW)) u_ctl (
        .clk          (clk),
        .rst          (rst),
        .period_stb   (period_stb),
        .thresh       (thresh),
        .rank_in      (rank_of),
        .volt_at_rank (volt_at_rank),
        .rank_q       (rank_q),
        .combined     (combined)
    );

    pwm_gate_mux #(.N_MOD(N_MOD)) u_mux (
        .clk      (clk),
        .rst      (rst),
        .gate_in  (gate_in),
        .rank_q   (rank_q),
        .combined (combined),
        .gate_out (gate_out)
    );

    // Module index held at each latched rank, for the port-level checks
    logic [N_MOD-1:0][RW-1:0] mod_of_rank;
    always_comb begin
        mod_of_rank = '0;
        for (int i = 0; i < N_MOD; i++) mod_of_rank[rank_q[i]] = RW'(i);
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> ((gate_out == '0) && (combined == '0)));

    for (genvar k = 0; k < G; k++) begin : g_chk
        a_r6_and_implies_or: assert property (@(posedge clk) disable iff (rst)
            ($past(combined[k]) && gate_out[$past(mod_of_rank[k])])
            |-> gate_out[$past(mod_of_rank[N_MOD-1-k])]);

        a_r5_direct_route: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(combined[k]))
            |-> ((gate_out[$past(mod_of_rank[k])] == $past(gate_in[k])) &&
                 (gate_out[$past(mod_of_rank[N_MOD-1-k])] == $past(gate_in[k+G]))));
    end

endmodule

// File: tb/tb_pwm_pair_combiner.sv
`timescale 1ns/100ps
module tb_pwm_pair_combiner;

    localparam int N  = 8;
    localparam int VW = 12;
    localparam int G  = N / 2;

    logic              clk = 1'b0;
    logic              rst;
    logic              period_stb;
    logic [VW-1:0]     thresh;
    logic [N*VW-1:0]   volt_flat;
    logic [N-1:0]      gate_in;
    logic [N-1:0]      gate_out;
    logic [G-1:0]      combined;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    int       m_ord [N];   // module at each rank
    bit [G-1:0] m_comb;

    always #2.5 clk = ~clk;

    pwm_pair_combiner #(.N_MOD(N), .VW(VW)) dut (
        .clk(clk), .rst(rst), .period_stb(period_stb), .thresh(thresh),
        .volt_flat(volt_flat), .gate_in(gate_in),
        .gate_out(gate_out), .combined(combined)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [VW-1:0] vol(input int i);
        return volt_flat[i*VW +: VW];
    endfunction

    function automatic bit beats(input int x, input int y);
        return (vol(x) > vol(y)) || ((vol(x) == vol(y)) && (x < y));
    endfunction

    task automatic model_reset();
        for (int r = 0; r < N; r++) m_ord[r] = r;
        m_comb = '0;
    endtask

    task automatic build_model();
        int t;
        for (int r = 0; r < N; r++) m_ord[r] = r;
        for (int a = 0; a < N-1; a++)
            for (int b = 0; b < N-1-a; b++)
                if (beats(m_ord[b+1], m_ord[b])) begin
                    t = m_ord[b]; m_ord[b] = m_ord[b+1]; m_ord[b+1] = t;
                end
        for (int k = 0; k < G; k++)
            m_comb[k] = ((vol(m_ord[k]) - vol(m_ord[N-1-k])) >= thresh);
    endtask

    function automatic logic [N-1:0] exp_gate(input logic [N-1:0] g);
        logic [N-1:0] e;
        e = '0;
        for (int k = 0; k < G; k++) begin
            if (m_comb[k]) begin
                e[m_ord[k]]     = g[k] & g[k+G];
                e[m_ord[N-1-k]] = g[k] | g[k+G];
            end else begin
                e[m_ord[k]]     = g[k];
                e[m_ord[N-1-k]] = g[k+G];
            end
        end
        return e;
    endfunction

    task automatic set_volts(input int v0, v1, v2, v3, v4, v5, v6, v7);
        volt_flat = {VW'(v7), VW'(v6), VW'(v5), VW'(v4), VW'(v3), VW'(v2), VW'(v1), VW'(v0)};
    endtask

    // Pulse the strobe for one cycle, update the model, check status
    task automatic strobe(input string tag);
        period_stb = 1'b1;
        @(negedge clk);
        period_stb = 1'b0;
        build_model();
        chk(tag, 32'(combined), 32'(m_comb));
    endtask

    task automatic drive_check(input int n, input string tag);
        for (int c = 0; c < n; c++) begin
            gate_in = N'($urandom);
            @(negedge clk);
            chk(tag, 32'(gate_out), 32'(exp_gate(gate_in)));
        end
    endtask

    initial begin
        logic [N-1:0] old_g;
        void'($urandom(32'h1A2B3C));
        rst = 1'b1; period_stb = 1'b0; gate_in = '1; thresh = '0; volt_flat = '0;
        repeat (3) @(negedge clk);
        chk("R1", 32'(gate_out), 0);
        chk("R1", 32'(combined), 0);
        rst = 1'b0;
        model_reset();
        drive_check(6, "R1");

        // Distinct voltages, huge threshold: all groups direct
        set_volts(420, 800, 100, 650, 300, 700, 500, 600);
        thresh = 12'hFFF;
        strobe("R9");
        drive_check(8, "R5");

        // Threshold zero: all groups combined
        thresh = 0;
        strobe("R9");
        drive_check(8, "R6");

        // Exact boundary: spreads 700, 400, 230, 100
        thresh = 230;
        strobe("R4");
        chk("R4", 32'(combined), 32'h7);
        drive_check(8, "R3");
        thresh = 231;
        strobe("R4");
        chk("R4", 32'(combined), 32'h3);
        drive_check(8, "R3");

        // Ties: all equal, index order decides rank
        set_volts(333, 333, 333, 333, 333, 333, 333, 333);
        thresh = 1;
        strobe("R2");
        chk("R2", 32'(combined), 0);
        drive_check(8, "R2");
        thresh = 0;
        strobe("R2");
        drive_check(8, "R2");

        // Partial ties
        set_volts(50, 900, 50, 900, 400, 50, 400, 900);
        thresh = 400;
        strobe("R2");
        drive_check(8, "R2");

        // Registered output: no change before the edge
        gate_in = 8'h5A;
        @(negedge clk);
        old_g = gate_in;
        gate_in = ~old_g;
        #1;
        chk("R7", 32'(gate_out), 32'(exp_gate(old_g)));
        @(negedge clk);
        chk("R7", 32'(gate_out), 32'(exp_gate(gate_in)));

        // Inputs changing between strobes have no effect
        set_volts(10, 20, 30, 40, 50, 60, 70, 80);
        thresh = 12'hFFF;
        @(negedge clk);
        chk("R8", 32'(combined), 32'(m_comb));
        drive_check(8, "R8");
        thresh = 0;
        drive_check(4, "R8");
        chk("R8", 32'(combined), 32'(m_comb));

        // Random periods
        for (int p = 0; p < 60; p++) begin
            for (int i = 0; i < N; i++)
                volt_flat[i*VW +: VW] = (p % 3 == 0) ? VW'($urandom_range(0, 7) * 64)
                                                     : VW'($urandom);
            thresh = (p % 4 == 0) ? VW'($urandom_range(0, 300)) : VW'($urandom);
            strobe("R9");
            drive_check(8, "R3");
        end

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R7: watchdog expired, got running expected finished");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule